// File: doc/BRIEF.md
# Eight-Line Nested Priority Interrupt Controller

This block gathers eight interrupt request lines and presents the most urgent one to a processor. Line 0 is the most urgent and line 7 the least. Software reaches the block through a byte-wide register port. A two-bit register select picks the command register, the data register or the level-select register, and single-cycle read and write strobes move the data. After reset the controller must be initialized with a short sequence of words, one of which sets the vector base. From then on, data writes load the mask.

Each line is either edge-triggered or level-triggered. An edge line requests only after it has been seen low since its last acknowledge. A level line requests whenever it is high. A request can interrupt only if it is unmasked and more urgent than every line already in service. Software accepts an interrupt with a one-cycle acknowledge strobe. In that same cycle the block returns the vector, and the in-service state is updated on the clock edge that closes the cycle. The acknowledge strobe and the register strobes are always accepted, so the block applies no back-pressure. A poll read of the command register performs the same acknowledge and returns the result in the read data. Interrupts are cleared by specific or non-specific end-of-interrupt commands.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, int_pending is 0, the mask and level-select registers read 0, and ack_vector reads base|7, where the default base is 0 for the primary build (parameter IS_PRIMARY=1) and 8 otherwise.
- R2: A command write (reg_sel=0) with bit 4 set starts initialization. It clears the mask, the in-service register and the read-control word, and sets every edge re-arm latch. It keeps the level-select register. The next three data writes are consumed as init words, and none of them loads the mask. The first of them sets the vector base from bits 7:3, with bits 2:0 forced to 0.
- R3: Outside the init sequence, a data write (reg_sel=1) loads the mask. A data read always returns the mask. A 1 in the mask blocks the matching line.
- R4: The effective request word is lines & (level_select | rearm). A re-arm bit is set at any clock edge where its line is low, and it is cleared when its line is acknowledged. An edge line therefore has to fall and rise again before it can request again.
- R5: Writing reg_sel=2 loads the level-select register, and a read of reg_sel=2 returns it. A 1 makes that line request whenever it is high, without the re-arm condition.
- R6: A request is eligible if it is effective, unmasked, and its line number is below the lowest in-service line. int_pending equals "any request eligible", and it follows changes in the same cycle.
- R7: During an ack_req cycle, ack_vector = base | lowest eligible line. At the closing edge, that line's in-service bit is set and its re-arm bit is cleared.
- R8: With no eligible line, ack_vector = base|7, and an acknowledge changes no state.
- R9: A command write with bits 4:3 = 00 is an operation word. Bit 7 is rotate, bit 6 is select-level, bit 5 is EOI and bits 2:0 give the level. Rotate=0, select-level=1, EOI=1 clears the named in-service bit. Rotate=0, select-level=0, EOI=1 clears the lowest set in-service bit.
- R10: An operation word is ignored if rotate is set, if neither EOI nor select-level is set, or if only select-level is set.
- R11: A command write with bit 4 = 0 and bit 3 = 1 loads the read-control word: bit 0 register-select, bit 1 read-register, bit 2 poll. A command read without poll returns the in-service register (register-select=1), the effective request word (register-select=0), or 0 if read-register is clear.
- R12: A command read with poll set clears poll and acts as an acknowledge. It returns {found, 0000, line}, which is 0x07 when nothing is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | 0 command, 1 data/mask, 2 level-select, 3 unused |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a poll read has side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| irq_lines | input | 8 | Request line levels |
| int_pending | output | 1 | An eligible request exists |
| ack_req | input | 1 | Acknowledge strobe |
| ack_vector | output | 8 | Vector for the current acknowledge |

## Verification
The hardest situation to reach is the nesting window. A less urgent line that has been raised must stay silent while a more urgent line is in service, and it must fire as soon as the blocking in-service bit is cleared. That state only exists after several acknowledges have stacked in-service bits, and after every served edge line has had its re-arm latch cleared. The stimulus raises lines 5, 3 and 1 in turn and acknowledges each, then uses non-specific and specific EOIs to peel off in-service bits. Line 6 is raised while line 3 is still in service. Before that, full sweeps of all 256 line patterns and all 256 mask values check priority selection arithmetically.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    ST_RAW  = 3'd0,
    ST_W2   = 3'd1,
    ST_W3   = 3'd2,
    ST_W4   = 3'd3,
    ST_RUN  = 3'd4
  } init_st_e;

  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_LVL  = 2'd2;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LINE_W   = 3,
  parameter logic [DATA_W-1:0] DEF_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_go_i,
  input  logic              ctl_wr_i,
  input  logic              data_wr_i,
  input  logic              lvl_wr_i,
  input  logic              poll_clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] base_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] lvl_o,
  output logic              rd_isr_o,
  output logic              rd_reg_o,
  output logic              poll_o
);
  localparam logic [DATA_W-1:0] BASE_KEEP = {{(DATA_W-LINE_W){1'b1}}, {LINE_W{1'b0}}};

  init_st_e          stage_q;
  logic [DATA_W-1:0] base_q, mask_q, lvl_q;
  logic [2:0]        ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_RAW;
      base_q  <= DEF_BASE & BASE_KEEP;
      mask_q  <= '0;
      lvl_q   <= '0;
      ctl_q   <= '0;
    end else begin
      if (lvl_wr_i) lvl_q <= wdata_i;
      if (init_go_i) begin
        stage_q <= ST_W2;
        base_q  <= DEF_BASE & BASE_KEEP;
        mask_q  <= '0;
        ctl_q   <= '0;
      end else begin
        if (ctl_wr_i) ctl_q <= wdata_i[2:0];
        else if (poll_clr_i) ctl_q[2] <= 1'b0;
        if (data_wr_i) begin
          unique case (stage_q)
            ST_W2: begin
              base_q  <= wdata_i & BASE_KEEP;
              stage_q <= ST_W3;
            end
            ST_W3:   stage_q <= ST_W4;
            ST_W4:   stage_q <= ST_RUN;
            default: mask_q  <= wdata_i;
          endcase
        end
      end
    end
  end

  assign base_o   = base_q;
  assign mask_o   = mask_q;
  assign lvl_o    = lvl_q;
  assign rd_isr_o = ctl_q[0];
  assign rd_reg_o = ctl_q[1];
  assign poll_o   = ctl_q[2];

  // R2
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_go_i |=> (mask_q == '0 && stage_q == ST_W2 && ctl_q == '0));

  // R2
  init_keeps_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_go_i && !lvl_wr_i) |=> $stable(lvl_q));
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines_i,
  input  logic [N_LINES-1:0] lvl_i,
  input  logic               rearm_all_i,
  input  logic [N_LINES-1:0] ack_clr_i,
  output logic [N_LINES-1:0] irr_o
);
  logic [N_LINES-1:0] arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= '1;
    else if (rearm_all_i) arm_q <= '1;
    else arm_q <= (arm_q & ~ack_clr_i) | ~lines_i;
  end

  assign irr_o = lines_i & (lvl_i | arm_q);

  // R4
  ack_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_clr_i && !rearm_all_i) |=> ((arm_q & $past(ack_clr_i)) == '0));

  // R4
  low_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lines_i != '1) |=> ((arm_q & ~$past(lines_i)) == ~$past(lines_i)));
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
  parameter int N_LINES = 8,
  parameter int LINE_W  = 3
) (
  input  logic [N_LINES-1:0] irr_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [N_LINES-1:0] isr_i,
  output logic               found_o,
  output logic [LINE_W-1:0]  line_o,
  output logic [N_LINES-1:0] onehot_o
);
  logic [N_LINES-1:0] top_isr, window, elig;

  assign top_isr = isr_i & (~isr_i + 1'b1);
  assign window  = top_isr - 1'b1;
  assign elig    = irr_i & ~mask_i & window;

  always_comb begin
    line_o = '1;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (elig[i]) line_o = LINE_W'(i);
    end
  end

  assign found_o  = |elig;
  assign onehot_o = found_o ? (N_LINES'(1) << line_o) : '0;
endmodule

// File: rtl/pic_service.sv
module pic_service #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_all_i,
  input  logic [N_LINES-1:0] set_i,
  input  logic [N_LINES-1:0] eoi_clr_i,
  output logic [N_LINES-1:0] isr_o
);
  logic [N_LINES-1:0] isr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else if (clr_all_i) isr_q <= '0;
    else isr_q <= (isr_q & ~eoi_clr_i) | set_i;
  end

  assign isr_o = isr_q;

  // R7
  ack_one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_i));

  // R7
  ack_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i && !clr_all_i) |=> ((isr_q & $past(set_i)) == $past(set_i)));

  // R9
  eoi_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|eoi_clr_i && set_i == '0) |=> ((isr_q & $past(eoi_clr_i)) == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_LINES    = 8,
  parameter bit IS_PRIMARY = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         reg_sel,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [N_LINES-1:0] wdata,
  output logic [N_LINES-1:0] rdata,
  input  logic [N_LINES-1:0] irq_lines,
  output logic               int_pending,
  input  logic               ack_req,
  output logic [N_LINES-1:0] ack_vector
);
  localparam int DATA_W = N_LINES;
  localparam int LINE_W = $clog2(N_LINES);
  localparam logic [DATA_W-1:0] DEF_BASE = IS_PRIMARY ? DATA_W'(0) : DATA_W'(N_LINES);

  logic cmd_wr, init_go, ctl_wr, op_wr, data_wr, lvl_wr;
  logic poll_rd, ack_go;
  logic [DATA_W-1:0] base, mask, lvl;
  logic rd_isr, rd_reg, poll;
  logic [N_LINES-1:0] irr, isr, ack_set, eoi_clr, top_isr;
  logic found;
  logic [LINE_W-1:0] line;

  assign cmd_wr  = wr_en && reg_sel == SEL_CMD;
  assign init_go = cmd_wr && wdata[4];
  assign ctl_wr  = cmd_wr && wdata[4:3] == 2'b01;
  assign op_wr   = cmd_wr && wdata[4:3] == 2'b00;
  assign data_wr = wr_en && reg_sel == SEL_DATA;
  assign lvl_wr  = wr_en && reg_sel == SEL_LVL;
  assign poll_rd = rd_en && reg_sel == SEL_CMD && poll;
  assign ack_go  = ack_req || poll_rd;

  pic_cfg_regs #(.DATA_W(DATA_W), .LINE_W(LINE_W), .DEF_BASE(DEF_BASE)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .init_go_i(init_go), .ctl_wr_i(ctl_wr), .data_wr_i(data_wr), .lvl_wr_i(lvl_wr),
    .poll_clr_i(poll_rd), .wdata_i(wdata),
    .base_o(base), .mask_o(mask), .lvl_o(lvl),
    .rd_isr_o(rd_isr), .rd_reg_o(rd_reg), .poll_o(poll)
  );

  pic_req_latch #(.N_LINES(N_LINES)) u_latch (
    .clk(clk), .rst_n(rst_n), .lines_i(irq_lines), .lvl_i(lvl),
    .rearm_all_i(init_go), .ack_clr_i(ack_set), .irr_o(irr)
  );

  pic_resolver #(.N_LINES(N_LINES), .LINE_W(LINE_W)) u_res (
    .irr_i(irr), .mask_i(mask), .isr_i(isr),
    .found_o(found), .line_o(line), .onehot_o(top_isr)
  );

  assign ack_set = ack_go ? top_isr : '0;

  always_comb begin
    eoi_clr = '0;
    if (op_wr && !wdata[7] && wdata[5]) begin
      if (wdata[6]) eoi_clr = N_LINES'(1) << wdata[LINE_W-1:0];
      else          eoi_clr = isr & (~isr + 1'b1);
    end
  end

  pic_service #(.N_LINES(N_LINES)) u_svc (
    .clk(clk), .rst_n(rst_n), .clr_all_i(init_go),
    .set_i(ack_set), .eoi_clr_i(eoi_clr), .isr_o(isr)
  );

  assign int_pending = found;
  assign ack_vector  = base | DATA_W'(line);

  always_comb begin
    unique case (reg_sel)
      SEL_CMD: begin
        if (poll)        rdata = {found, {(DATA_W-1-LINE_W){1'b0}}, line};
        else if (rd_reg) rdata = rd_isr ? isr : irr;
        else             rdata = '0;
      end
      SEL_DATA: rdata = mask;
      SEL_LVL:  rdata = lvl;
      default:  rdata = '0;
    endcase
  end

  // R6
  pending_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_pending |-> ((irq_lines & ~mask) != '0));

  // R8
  spurious_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_go && !found && !wr_en) |=> $stable(isr));

  // R10
  op_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && (wdata[7] || !wdata[5]) && !ack_go) |=> $stable(isr));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] reg_sel = 0;
  logic wr_en = 0, rd_en = 0, ack_req = 0;
  logic [7:0] wdata = 0, rdata, irq_lines = 0, ack_vector;
  logic int_pending;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_lines(irq_lines), .int_pending(int_pending),
    .ack_req(ack_req), .ack_vector(ack_vector)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); ack_req = 1; #1 v = ack_vector;
    @(negedge clk); ack_req = 0;
  endtask

  task automatic lines(input logic [7:0] l);
    @(negedge clk); irq_lines = l; #1;
  endtask

  task automatic init(input logic [7:0] b);
    wr(0, 8'h11); wr(1, b); wr(1, 8'h04); wr(1, 8'h01);
  endtask

  function automatic logic [7:0] low_idx(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 8'(i);
    return 8'd7;
  endfunction

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 pending", {7'd0, int_pending}, 8'h00);
    chk("R1 vector", ack_vector, 8'h07);
    rd(1, v); chk("R1 mask", v, 8'h00);
    rd(2, v); chk("R1 lvl", v, 8'h00);

    init(8'h37);
    ack(v); chk("R2 base low bits forced", v, 8'h37);
    wr(1, 8'h00);
    rd(1, v); chk("R3 mask after init", v, 8'h00);
    wr(2, 8'hFF);
    rd(2, v); chk("R5 lvl readback", v, 8'hFF);
    wr(0, 8'h0A);
    // R6 R4 R5 sweep of line patterns in level mode
    for (int p = 0; p < 256; p++) begin
      lines(8'(p));
      chk("R6 pending sweep", {7'd0, int_pending}, {7'd0, p != 0});
      chk("R7 vector sweep", ack_vector, 8'h30 | low_idx(8'(p)));
      rd(0, v); chk("R4 irr sweep", v, 8'(p));
    end
    // R3 mask sweep
    lines(8'hFF);
    for (int m = 0; m < 256; m++) begin
      wr(1, 8'(m));
      chk("R3 pending mask", {7'd0, int_pending}, {7'd0, m != 255});
      chk("R3 vector mask", ack_vector, 8'h30 | low_idx(~8'(m)));
    end
    wr(1, 8'h00); wr(2, 8'h00); lines(8'h00);
    @(negedge clk);

    // R7 nesting, edge mode
    lines(8'h20); chk("R6 pending edge", {7'd0, int_pending}, 8'h01);
    ack(v); chk("R7 ack 5", v, 8'h35);
    lines(8'h28); ack(v); chk("R7 ack 3", v, 8'h33);
    lines(8'h2A); ack(v); chk("R7 ack 1", v, 8'h31);
    wr(0, 8'h0B); rd(0, v); chk("R11 isr read", v, 8'h2A);
    chk("R4 no rerequest", {7'd0, int_pending}, 8'h00);
    wr(0, 8'h20); rd(0, v); chk("R9 nonspecific eoi", v, 8'h28);
    wr(0, 8'h65); rd(0, v); chk("R9 specific eoi", v, 8'h08);
    lines(8'h6A); chk("R6 blocked by in-service", {7'd0, int_pending}, 8'h00);
    wr(0, 8'h63); chk("R6 unblocked", {7'd0, int_pending}, 8'h01);
    ack(v); chk("R7 ack 6", v, 8'h36);
    rd(0, v); chk("R7 isr 6", v, 8'h40);
    wr(0, 8'h20);
    wr(0, 8'h0A); rd(0, v); chk("R4 irr disarmed", v, 8'h00);
    lines(8'h68); @(negedge clk); lines(8'h6A);
    rd(0, v); chk("R4 rearm after low", v, 8'h02);
    wr(2, 8'h08); rd(0, v); chk("R5 level bypass", v, 8'h0A);

    // R10 ignored operation words
    ack(v); chk("R7 ack 1 again", v, 8'h31);
    wr(0, 8'hE0); wr(0, 8'h00); wr(0, 8'h42);
    wr(0, 8'h0B); rd(0, v); chk("R10 ignored ops", v, 8'h02);
    wr(0, 8'h20); rd(0, v); chk("R9 clear", v, 8'h00);

    // R12 poll
    wr(0, 8'h0C); rd(0, v); chk("R12 poll found", v, 8'h83);
    wr(0, 8'h0B); rd(0, v); chk("R12 poll marks isr", v, 8'h08);
    wr(0, 8'h0C); rd(0, v); chk("R12 poll empty", v, 8'h07);
    rd(0, v); chk("R12 poll cleared R11 zero read", v, 8'h00);
    // R8 spurious
    ack(v); chk("R8 spurious vector", v, 8'h37);
    wr(0, 8'h0B); rd(0, v); chk("R8 no change", v, 8'h08);

    // R2 re-initialization
    wr(1, 8'h55);
    wr(0, 8'h11);
    rd(1, v); chk("R2 mask cleared", v, 8'h00);
    wr(1, 8'h48);
    rd(1, v); chk("R2 init word not mask", v, 8'h00);
    wr(1, 8'h04); wr(1, 8'h01);
    rd(2, v); chk("R2 lvl kept", v, 8'h08);
    chk("R2 new base and rearm", ack_vector, 8'h49);
    rd(0, v); chk("R2 ctl cleared", v, 8'h00);
    wr(0, 8'h0B); rd(0, v); chk("R2 isr cleared", v, 8'h00);
    wr(1, 8'h02); chk("R3 mask blocks", ack_vector, 8'h4B);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule